// File: doc/BRIEF.md
# GPIO Bank Interrupt Summary and End-of-Interrupt Controller

This block sits above the per-pin detectors of a GPIO bank and folds their pending flags into a compact summary. Each summary bit covers a group of four neighbouring pins. The summary is split into a low and a high 32-bit word. Any set summary bit drives one interrupt line toward the host. The host ends a service pass by writing the end-of-interrupt bit of the master control register. The line then drops for one cycle. It comes back at once if work is still pending.

The master control register also holds a status-blocking enable and a 12-bit blocking length. When blocking is enabled, a software write to the debounce settings of any pin opens a window that lasts the programmed number of reference ticks. Inside the window the summary is frozen, so no new status is produced for any pin, and every pin's interrupt-enable bit reads back as 0.

Top module: `pirq_summary_ctrl`

## Requirements
- R1: One clock after a cycle in which no blocking window is active, summary bit g equals the OR of pin pending inputs 4g, 4g+1, 4g+2 and 4g+3. Bits 0..31 appear on the low word (bit g at position g) and bits 32..45 on the high word (bit g at position g-32).
- R2: Summary bits 46..63, which are high-word positions 14..31, always read 0.
- R3: The interrupt output is 1 in the cycle after the summary is nonzero and 0 in the cycle after it is zero, unless R4 applies.
- R4: A control write with the end-of-interrupt bit at 1 forces the interrupt output to 0 in the next cycle. The bit is not stored, so the line re-asserts one cycle later if the summary is still nonzero.
- R5: A control write loads the blocking-enable and blocking-length fields, which are read back on their own outputs. Both are 0 after reset.
- R6: With blocking enabled and a nonzero length L, a debounce-write strobe opens a window from the next cycle. The window ends after L cycles in which the tick input is 1. Throughout the window the interrupt-enable readback is 0 for every pin.
- R7: While a window is active the summary words hold their value and ignore pin changes. They follow the pins again one clock after the window ends.
- R8: A debounce-write strobe during an active window restarts the window at the full length. If a strobe and a tick arrive in the same cycle, the strobe takes precedence.
- R9: With blocking disabled, or with a length of 0, a debounce-write strobe has no effect: the interrupt-enable readback equals the per-pin enable input and the summary keeps tracking the pins.
- R10: After reset the summary words are 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_pend_i | input | NUM_PINS | Per-pin pending flags from the pin detectors |
| pin_ien_i | input | NUM_PINS | Per-pin stored interrupt-enable bits |
| dbnc_wr_i | input | 1 | Strobe: software wrote some pin's debounce settings |
| tick_i | input | 1 | Reference tick that paces the blocking window |
| ctrl_we_i | input | 1 | Master control register write strobe |
| ctrl_eoi_i | input | 1 | Write data: end-of-interrupt bit |
| ctrl_blk_en_i | input | 1 | Write data: status-blocking enable |
| ctrl_blk_len_i | input | LEN_W | Write data: blocking length in ticks |
| blk_en_o | output | 1 | Stored blocking enable |
| blk_len_o | output | LEN_W | Stored blocking length |
| sum_lo_o | output | 32 | Summary bits 0..31 |
| sum_hi_o | output | 32 | Summary bits 32..63 |
| irq_o | output | 1 | Interrupt line to the host |
| ien_rd_o | output | NUM_PINS | Interrupt-enable readback, forced to 0 inside a window |

## Verification
The properties assume that the pending and enable vectors are synchronous to the clock. They also assume that a control write presents all fields at once, so an end-of-interrupt write rewrites the blocking fields as well. The stimulus changes every input well away from the clock edge. Each end-of-interrupt write resends the blocking enable and length the bench last programmed, and the tick input is held for exactly one cycle at a time. With this discipline the window length in ticks can be counted directly from the bench's own stimulus.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int WORD_W = 32;
  localparam int SUM_W  = 2 * WORD_W;
  localparam int GRP_SZ = 4;
  localparam int LEN_W  = 12;

  typedef struct packed {
    logic             blk_en;
    logic [LEN_W-1:0] blk_len;
  } mstr_cfg_t;
endpackage

// File: rtl/pirq_grp_or.sv
module pirq_grp_or #(
  parameter int NUM_PINS = 184,
  parameter int GRP_SZ   = 4,
  parameter int OUT_W    = 64
) (
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [OUT_W-1:0]    grp_o
);
  localparam int NUM_GRP = (NUM_PINS + GRP_SZ - 1) / GRP_SZ;
  localparam int PAD_W   = NUM_GRP * GRP_SZ;

  logic [PAD_W-1:0] pend_pad;
  assign pend_pad = PAD_W'(pend_i);

  for (genvar g = 0; g < OUT_W; g++) begin : g_grp
    if (g < NUM_GRP) begin : g_live
      assign grp_o[g] = |pend_pad[g*GRP_SZ +: GRP_SZ];
    end else begin : g_tie
      assign grp_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/pirq_blk_timer.sv
module pirq_blk_timer #(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dbnc_wr_i,
  input  logic             tick_i,
  output logic             act_o
);
  logic [LEN_W-1:0] cnt_q;

  // strobe reloads before tick decrements
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (dbnc_wr_i && en_i)         cnt_q <= len_i;
    else if (tick_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign act_o = (cnt_q != '0);
endmodule

// File: rtl/pirq_line.sv
module pirq_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eoi_i,
  input  logic any_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (eoi_i) irq_q <= 1'b0;
    else            irq_q <= any_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pirq_summary_ctrl.sv
module pirq_summary_ctrl #(
  parameter int NUM_PINS = 184,
  parameter int LEN_W    = pirq_pkg::LEN_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_pend_i,
  input  logic [NUM_PINS-1:0] pin_ien_i,
  input  logic                dbnc_wr_i,
  input  logic                tick_i,
  input  logic                ctrl_we_i,
  input  logic                ctrl_eoi_i,
  input  logic                ctrl_blk_en_i,
  input  logic [LEN_W-1:0]    ctrl_blk_len_i,
  output logic                blk_en_o,
  output logic [LEN_W-1:0]    blk_len_o,
  output logic [31:0]         sum_lo_o,
  output logic [31:0]         sum_hi_o,
  output logic                irq_o,
  output logic [NUM_PINS-1:0] ien_rd_o
);
  localparam int WORD_W = pirq_pkg::WORD_W;
  localparam int SUM_W  = pirq_pkg::SUM_W;
  localparam int GRP_SZ = pirq_pkg::GRP_SZ;

  logic             cfg_en_q;
  logic [LEN_W-1:0] cfg_len_q;
  logic [SUM_W-1:0] sum_d, sum_q;
  logic             blk_act;
  logic             eoi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_en_q  <= 1'b0;
      cfg_len_q <= '0;
    end else if (ctrl_we_i) begin
      cfg_en_q  <= ctrl_blk_en_i;
      cfg_len_q <= ctrl_blk_len_i;
    end
  end

  assign eoi = ctrl_we_i & ctrl_eoi_i;

  pirq_grp_or #(
    .NUM_PINS (NUM_PINS),
    .GRP_SZ   (GRP_SZ),
    .OUT_W    (SUM_W)
  ) u_grp (
    .pend_i (pin_pend_i),
    .grp_o  (sum_d)
  );

  pirq_blk_timer #(
    .LEN_W (LEN_W)
  ) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cfg_en_q),
    .len_i     (cfg_len_q),
    .dbnc_wr_i (dbnc_wr_i),
    .tick_i    (tick_i),
    .act_o     (blk_act)
  );

  // freeze status while blocked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sum_q <= '0;
    else if (!blk_act) sum_q <= sum_d;
  end

  pirq_line u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .eoi_i  (eoi),
    .any_i  (|sum_q),
    .irq_o  (irq_o)
  );

  assign sum_lo_o  = sum_q[WORD_W-1:0];
  assign sum_hi_o  = sum_q[SUM_W-1:WORD_W];
  assign blk_en_o  = cfg_en_q;
  assign blk_len_o = cfg_len_q;
  assign ien_rd_o  = blk_act ? '0 : pin_ien_i;
endmodule

// File: rtl/pirq_summary_chk.sv
module pirq_summary_chk #(
  parameter int NUM_PINS = 184,
  parameter int LEN_W    = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pin_pend_i,
  input logic                ctrl_we_i,
  input logic                ctrl_eoi_i,
  input logic                dbnc_wr_i,
  input logic                blk_en_o,
  input logic [LEN_W-1:0]    blk_len_o,
  input logic [31:0]         sum_lo_o,
  input logic [31:0]         sum_hi_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] ien_rd_o,
  input logic                blk_act
);
  localparam int NUM_GRP = (NUM_PINS + 3) / 4;

  logic [63:0] sum_all, model;
  assign sum_all = {sum_hi_o, sum_lo_o};

  always_comb begin
    model = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (pin_pend_i[p]) model[p/4] = 1'b1;
  end

  // R1
  grp_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_act |=> sum_all == $past(model));

  // R2
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_all >> NUM_GRP) == 64'd0);

  // R3
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_all == 64'd0 |=> !irq_o);

  // R3
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_all != 64'd0 && !(ctrl_we_i && ctrl_eoi_i)) |=> irq_o);

  // R4
  eoi_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_eoi_i) |=> !irq_o);

  // R6
  ien_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbnc_wr_i && blk_en_o && blk_len_o != '0) |=> ien_rd_o == '0);

  // R7
  sum_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_act |=> $stable(sum_all));
endmodule

bind pirq_summary_ctrl pirq_summary_chk #(
  .NUM_PINS (NUM_PINS),
  .LEN_W    (LEN_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pin_pend_i (pin_pend_i),
  .ctrl_we_i  (ctrl_we_i),
  .ctrl_eoi_i (ctrl_eoi_i),
  .dbnc_wr_i  (dbnc_wr_i),
  .blk_en_o   (blk_en_o),
  .blk_len_o  (blk_len_o),
  .sum_lo_o   (sum_lo_o),
  .sum_hi_o   (sum_hi_o),
  .irq_o      (irq_o),
  .ien_rd_o   (ien_rd_o),
  .blk_act    (blk_act)
);

// File: tb/tb_pirq_summary_ctrl.sv
`timescale 1ns/1ps
module tb_pirq_summary_ctrl;
  localparam int NP = 184;
  localparam int LW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pin_pend_i = '0;
  logic [NP-1:0] pin_ien_i = '1;
  logic          dbnc_wr_i = 1'b0;
  logic          tick_i = 1'b0;
  logic          ctrl_we_i = 1'b0;
  logic          ctrl_eoi_i = 1'b0;
  logic          ctrl_blk_en_i = 1'b0;
  logic [LW-1:0] ctrl_blk_len_i = '0;
  logic          blk_en_o;
  logic [LW-1:0] blk_len_o;
  logic [31:0]   sum_lo_o, sum_hi_o;
  logic          irq_o;
  logic [NP-1:0] ien_rd_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  pirq_summary_ctrl dut (.*);

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_ien(string req, logic [NP-1:0] exp);
    n_chk++;
    if (ien_rd_o !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, ien_rd_o, exp);
    end
  endtask

  function automatic logic [63:0] exp_sum(logic [NP-1:0] pend);
    logic [63:0] e = '0;
    for (int p = 0; p < NP; p++)
      if (pend[p]) e = e | (64'd1 << (p >> 2));
    return e;
  endfunction

  task automatic ctrl_wr(logic eoi, logic en, logic [LW-1:0] len);
    ctrl_we_i = 1'b1; ctrl_eoi_i = eoi; ctrl_blk_en_i = en; ctrl_blk_len_i = len;
    step();
    ctrl_we_i = 1'b0; ctrl_eoi_i = 1'b0;
  endtask

  task automatic dbnc_pulse(logic with_tick);
    dbnc_wr_i = 1'b1; tick_i = with_tick;
    step();
    dbnc_wr_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic tick_pulse();
    tick_i = 1'b1;
    step();
    tick_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [NP-1:0] pa, pb;
    logic [31:0] lfsr;
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R10 / R5 reset state
    chk("R10", {sum_hi_o, sum_lo_o}, 64'd0);
    chk("R10", {63'd0, irq_o}, 64'd0);
    chk("R5", {63'd0, blk_en_o}, 64'd0);
    chk("R5", {52'd0, blk_len_o}, 64'd0);
    chk_ien("R9", pin_ien_i);

    // R1 / R3 single-pin sweep
    for (int p = 0; p < NP; p++) begin
      pin_pend_i = '0;
      pin_pend_i[p] = 1'b1;
      step();
      chk("R1", {sum_hi_o, sum_lo_o}, 64'd1 << (p >> 2));
      step();
      chk("R3", {63'd0, irq_o}, 64'd1);
    end
    pin_pend_i = '0;
    step(); step();
    chk("R3", {63'd0, irq_o}, 64'd0);

    // R2 all pins set
    pin_pend_i = '1;
    step();
    chk("R2", {32'd0, sum_hi_o}, 64'h0000_3FFF);
    chk("R1", {32'd0, sum_lo_o}, 64'hFFFF_FFFF);

    // R1 pseudo-random patterns
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 40; k++) begin
      for (int w = 0; w < NP; w++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        pin_pend_i[w] = lfsr[0] & lfsr[3] & lfsr[7];
      end
      step();
      chk("R1", {sum_hi_o, sum_lo_o}, exp_sum(pin_pend_i));
      chk("R2", {32'd0, sum_hi_o} >> 14, 64'd0);
    end

    // R4 EOI with pending and without
    pin_pend_i = '0; pin_pend_i[101] = 1'b1;
    step(); step();
    chk("R3", {63'd0, irq_o}, 64'd1);
    ctrl_wr(1'b1, 1'b0, '0);
    chk("R4", {63'd0, irq_o}, 64'd0);
    step();
    chk("R4", {63'd0, irq_o}, 64'd1);
    pin_pend_i = '0;
    step(); step();
    ctrl_wr(1'b1, 1'b0, '0);
    chk("R4", {63'd0, irq_o}, 64'd0);
    step();
    chk("R4", {63'd0, irq_o}, 64'd0);

    // R9 blocking disabled, then zero length
    pin_ien_i = {(NP/2){2'b01}};
    ctrl_wr(1'b0, 1'b0, 12'd5);
    chk("R5", {52'd0, blk_len_o}, 64'd5);
    dbnc_pulse(1'b0);
    chk_ien("R9", pin_ien_i);
    ctrl_wr(1'b0, 1'b1, 12'd0);
    chk("R5", {63'd0, blk_en_o}, 64'd1);
    dbnc_pulse(1'b0);
    chk_ien("R9", pin_ien_i);
    pin_pend_i = '0; pin_pend_i[7] = 1'b1;
    step();
    chk("R9", {sum_hi_o, sum_lo_o}, 64'd2);
    pin_ien_i = '1;

    // R6 / R7 window of 5 ticks
    pa = '0; pa[0] = 1'b1; pa[183] = 1'b1;
    pb = '0; pb[64] = 1'b1;
    pin_pend_i = pa;
    ctrl_wr(1'b0, 1'b1, 12'd5);
    chk("R5", {52'd0, blk_len_o}, 64'd5);
    dbnc_pulse(1'b0);
    chk_ien("R6", '0);
    pin_pend_i = pb;
    step(); step();
    chk("R7", {sum_hi_o, sum_lo_o}, exp_sum(pa));
    chk_ien("R6", '0);
    for (int t = 0; t < 4; t++) begin
      tick_pulse();
      chk_ien("R6", '0);
    end
    tick_pulse();
    chk_ien("R6", '1);
    chk("R7", {sum_hi_o, sum_lo_o}, exp_sum(pa));
    step();
    chk("R7", {sum_hi_o, sum_lo_o}, exp_sum(pb));

    // R8 restart mid-window, strobe beats tick
    dbnc_pulse(1'b0);
    for (int t = 0; t < 3; t++) tick_pulse();
    chk_ien("R8", '0);
    dbnc_pulse(1'b1);
    for (int t = 0; t < 4; t++) begin
      tick_pulse();
      chk_ien("R8", '0);
    end
    tick_pulse();
    chk_ien("R8", '1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule